// File: doc/BRIEF.md
# Quasi-Bidirectional Port Drive Controller

This block owns the output latch of an 8-bit quasi-bidirectional I/O port and turns it into per-pin drive enables for the pad cells. A pin whose latch bit is 0 is pulled low hard. A pin whose latch bit is 1 is held high only weakly, so an external device can still pull it down and the pin can be read as an input. Three pull-up enables are timed separately. The weak pull-up follows the latch. The medium pull-up also needs the pin to be seen high. The strong pull-up fires for a short burst after the latch goes from 0 to 1, which speeds up the rising edge.

A processor writes the latch through a write strobe with data. It reads back either the latch, for read-modify-write sequences, or the synchronized pin levels. One global control input switches off the weak keeper on pins whose latch is 0. The analog side is reduced to enable signals and digital pin levels.

Top module: `qbio_port_ctrl`

## Requirements
- R1: While reset is low and after it is released, the latch reads all ones (8'hFF), every pull-down enable is 0 and every strong pull-up enable is 0.
- R2: When `wrEn` is high at a rising clock edge, the latch takes `wrData` and `latchRd` shows it from that edge on. Without `wrEn` the latch keeps its value.
- R3: `pullDnEn[i]` is the inverse of latch bit i.
- R4: `weakUpEn[i]` is 1 whenever latch bit i is 1, whatever `keeperOff` is.
- R5: On a pin whose latch bit is 0, `weakUpEn[i]` is 1 when `keeperOff` is 0 and 0 when `keeperOff` is 1. The change follows `keeperOff` in the same cycle.
- R6: `midUpEn[i]` is 1 exactly when latch bit i is 1 and the synchronized level of pin i is 1.
- R7: `pinRd` is `pinIn` delayed through two clocked stages. A level applied before edge k appears on `pinRd` after edge k+1. The synchronizer stages reset to 0.
- R8: A write that changes latch bit i from 0 to 1 makes `strongUpEn[i]` 1 for exactly two clock cycles, starting at that write edge.
- R9: A write that keeps bit i at 1 during its strong pulse neither extends nor restarts the pulse. A write that returns bit i to 0 ends the pulse at that edge.
- R10: A new 0-to-1 change of bit i after a cancelled or finished pulse starts a fresh two-cycle pulse.
- R11: On no pin is `pullDnEn[i]` 1 in the same cycle as `midUpEn[i]` or `strongUpEn[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Latch write strobe |
| wrData | input | 8 | Data written to the latch |
| keeperOff | input | 1 | Turns off the weak pull-up on pins whose latch bit is 0 |
| pinIn | input | 8 | Logic level seen on each pin |
| pullDnEn | output | 8 | Strong pull-down enable per pin |
| weakUpEn | output | 8 | Weak pull-up enable per pin |
| midUpEn | output | 8 | Medium pull-up enable per pin |
| strongUpEn | output | 8 | Brief strong pull-up enable per pin |
| latchRd | output | 8 | Latch contents read path |
| pinRd | output | 8 | Synchronized pin level read path |

## Verification
A wrong latch value shows up in the same cycle on `latchRd`, `pullDnEn` and `weakUpEn`. A wrong boost counter shows up as a strong pulse that is one cycle short or long, or that survives a write of 0. It is visible on `strongUpEn` at the first edge where the count differs. A synchronizer with a missing or extra stage shifts `pinRd` and `midUpEn` by one cycle, so the bench compares every output against its reference on every clock.

// File: rtl/qbio_pkg.sv
package qbio_pkg;
  // Strobes passed from the control section to the datapath
  typedef struct packed {
    logic load;       // latch takes write data this edge
    logic keeperOff;  // low-state weak keeper suppressed
  } qbioStrobe_t;
endpackage

// File: rtl/qbio_boost_ctl.sv
module qbio_boost_ctl
  import qbio_pkg::*;
#(
  parameter int W     = 8,
  parameter int BOOST = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  input  logic         keeperOff,
  input  logic [W-1:0] latchQ,
  output qbioStrobe_t  strobe,
  output logic [W-1:0] boostOn
);
  localparam int CW = $clog2(BOOST + 1);
  localparam logic [CW-1:0] BOOST_LD = CW'(BOOST);

  logic [W-1:0] riseMask;
  logic [W-1:0] fallMask;

  always_comb begin
    strobe.load      = wrEn;
    strobe.keeperOff = keeperOff;
    riseMask = {W{wrEn}} & wrData & ~latchQ;
    fallMask = {W{wrEn}} & ~wrData;
  end

  for (genvar i = 0; i < W; i++) begin : gPin
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            cnt <= '0;
      else if (fallMask[i]) cnt <= '0;
      else if (riseMask[i]) cnt <= BOOST_LD;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
    assign boostOn[i] = (cnt != '0);
  end
endmodule

// File: rtl/qbio_port_dp.sv
module qbio_port_dp
  import qbio_pkg::*;
#(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  qbioStrobe_t  strobe,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] pinIn,
  input  logic [W-1:0] boostOn,
  output logic [W-1:0] latchQ,
  output logic [W-1:0] pinSync,
  output logic [W-1:0] pullDnEn,
  output logic [W-1:0] weakUpEn,
  output logic [W-1:0] midUpEn,
  output logic [W-1:0] strongUpEn
);
  logic [W-1:0] syncStg [SYNC];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            latchQ <= '1;
    else if (strobe.load) latchQ <= wrData;
  end

  for (genvar s = 0; s < SYNC; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncStg[s] <= '0;
      else if (s == 0) syncStg[s] <= pinIn;
      else syncStg[s] <= syncStg[(s == 0) ? 0 : s - 1];
    end
  end

  assign pinSync = syncStg[SYNC-1];

  always_comb begin
    pullDnEn   = ~latchQ;
    weakUpEn   = latchQ | {W{~strobe.keeperOff}};
    midUpEn    = latchQ & pinSync;
    strongUpEn = latchQ & boostOn;
  end
endmodule

// File: rtl/qbio_port_ctrl.sv
module qbio_port_ctrl
  import qbio_pkg::*;
#(
  parameter int W     = 8,
  parameter int SYNC  = 2,
  parameter int BOOST = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  input  logic         keeperOff,
  input  logic [W-1:0] pinIn,
  output logic [W-1:0] pullDnEn,
  output logic [W-1:0] weakUpEn,
  output logic [W-1:0] midUpEn,
  output logic [W-1:0] strongUpEn,
  output logic [W-1:0] latchRd,
  output logic [W-1:0] pinRd
);
  qbioStrobe_t  strobe;
  logic [W-1:0] latchQ;
  logic [W-1:0] boostOn;

  qbio_boost_ctl #(.W(W), .BOOST(BOOST)) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .keeperOff(keeperOff), .latchQ(latchQ),
    .strobe(strobe), .boostOn(boostOn)
  );

  qbio_port_dp #(.W(W), .SYNC(SYNC)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .pinIn(pinIn), .boostOn(boostOn), .latchQ(latchQ),
    .pinSync(pinRd), .pullDnEn(pullDnEn), .weakUpEn(weakUpEn),
    .midUpEn(midUpEn), .strongUpEn(strongUpEn)
  );

  assign latchRd = latchQ;
endmodule

// File: rtl/qbio_port_chk.sv
module qbio_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         wrEn,
  input logic [W-1:0] wrData,
  input logic         keeperOff,
  input logic [W-1:0] pullDnEn,
  input logic [W-1:0] weakUpEn,
  input logic [W-1:0] midUpEn,
  input logic [W-1:0] strongUpEn,
  input logic [W-1:0] latchRd,
  input logic [W-1:0] pinRd
);
  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(latchRd));

  assert_latch_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> latchRd == $past(wrData));

  assert_weak_on_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (weakUpEn & latchRd) == latchRd);

  assert_keeper_R5: assert property (@(posedge clk) disable iff (!rstN)
    keeperOff |-> (weakUpEn & ~latchRd) == '0);

  assert_mid_R6: assert property (@(posedge clk) disable iff (!rstN)
    midUpEn == (latchRd & pinRd));

  assert_boost_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && |(wrData & ~latchRd)) |=>
      (strongUpEn & $past(wrData & ~latchRd)) == $past(wrData & ~latchRd));

  assert_boost_cancel_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (strongUpEn & ~$past(wrData)) == '0);

  assert_no_fight_R11: assert property (@(posedge clk) disable iff (!rstN)
    (pullDnEn & (midUpEn | strongUpEn)) == '0);
endmodule

bind qbio_port_ctrl qbio_port_chk #(.W(W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .keeperOff(keeperOff), .pullDnEn(pullDnEn), .weakUpEn(weakUpEn),
  .midUpEn(midUpEn), .strongUpEn(strongUpEn), .latchRd(latchRd),
  .pinRd(pinRd)
);

// File: tb/sim_qbio_port_ctrl.sv
module sim_qbio_port_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rstN = 0;
  logic       wrEn = 0;
  logic [7:0] wrData = '0;
  logic       keeperOff = 0;
  logic [7:0] pinIn = '0;
  logic [7:0] pullDnEn, weakUpEn, midUpEn, strongUpEn, latchRd, pinRd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [7:0] mLatch = 8'hFF;
  logic [7:0] mS1 = '0, mS2 = '0;
  int         mCnt [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  qbio_port_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .keeperOff(keeperOff), .pinIn(pinIn), .pullDnEn(pullDnEn),
    .weakUpEn(weakUpEn), .midUpEn(midUpEn), .strongUpEn(strongUpEn),
    .latchRd(latchRd), .pinRd(pinRd)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] mStrong();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = (mCnt[i] != 0) && mLatch[i];
    return v;
  endfunction

  task automatic compareAll();
    logic [7:0] s;
    s = mStrong();
    chk("R2 latchRd", latchRd, mLatch);
    chk("R3 pullDnEn", pullDnEn, ~mLatch);
    chk("R4/R5 weakUpEn", weakUpEn, mLatch | (keeperOff ? 8'h00 : 8'hFF));
    chk("R6 midUpEn", midUpEn, mLatch & mS2);
    chk("R7 pinRd", pinRd, mS2);
    chk("R8 strongUpEn", strongUpEn, s);
    chk("R11 no fight", pullDnEn & (midUpEn | strongUpEn), 8'h00);
  endtask

  // drive inputs, take one edge, update model, compare at the falling edge
  task automatic step(logic we, logic [7:0] d, logic ko, logic [7:0] p);
    logic [7:0] rise;
    wrEn = we; wrData = d; keeperOff = ko; pinIn = p;
    @(posedge clk);
    rise = (we ? d : 8'h00) & ~mLatch;
    for (int i = 0; i < 8; i++) begin
      if (we && !d[i])   mCnt[i] = 0;
      else if (rise[i])  mCnt[i] = 2;
      else if (mCnt[i] > 0) mCnt[i]--;
    end
    if (we) mLatch = d;
    mS2 = mS1; mS1 = p;
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    for (int i = 0; i < 8; i++) mCnt[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 latch in reset", latchRd, 8'hFF);
    chk("R1 pulldown in reset", pullDnEn, 8'h00);
    chk("R1 strong in reset", strongUpEn, 8'h00);
    rstN = 1;
    step(0, 8'h00, 0, 8'h00);
    chk("R1 latch after reset", latchRd, 8'hFF);
    chk("R1 strong after reset", strongUpEn, 8'h00);

    // R3/R5: all low, keeper on then off
    step(1, 8'h00, 0, 8'hFF);
    chk("R3 all pulled down", pullDnEn, 8'hFF);
    chk("R5 keeper on", weakUpEn, 8'hFF);
    step(0, 8'h00, 1, 8'hFF);
    chk("R5 keeper off", weakUpEn, 8'h00);

    // R8: rise on low nibble, two-cycle pulse
    step(1, 8'h0F, 1, 8'hFF);
    chk("R8 pulse cycle 1", strongUpEn, 8'h0F);
    chk("R4 weak on high bits", weakUpEn, 8'h0F);
    step(0, 8'h00, 1, 8'hFF);
    chk("R8 pulse cycle 2", strongUpEn, 8'h0F);
    chk("R6 mid with pins high", midUpEn, 8'h0F);
    step(0, 8'h00, 1, 8'h00);
    chk("R8 pulse released", strongUpEn, 8'h00);
    chk("R7 pin not yet seen low", pinRd, 8'hFF);
    step(0, 8'h00, 1, 8'h00);
    chk("R7 pin low after two edges", pinRd, 8'h00);
    chk("R6 mid drops when pin low", midUpEn, 8'h00);

    // R9: rewrite with 1 does not extend
    step(1, 8'hF0, 0, 8'h00);
    step(1, 8'hF0, 0, 8'h00);
    chk("R9 same-value rewrite keeps count", strongUpEn, 8'hF0);
    step(1, 8'hF0, 0, 8'h00);
    chk("R9 no extension", strongUpEn, 8'h00);
    // R9: cancel by writing 0
    step(1, 8'h00, 0, 8'h00);
    step(1, 8'h01, 0, 8'h00);
    step(1, 8'h00, 0, 8'h00);
    chk("R9 cancelled", strongUpEn, 8'h00);
    // R10: fresh rise restarts
    step(1, 8'h01, 0, 8'h00);
    chk("R10 restart cycle 1", strongUpEn, 8'h01);
    step(0, 8'h00, 0, 8'h00);
    chk("R10 restart cycle 2", strongUpEn, 8'h01);
    step(0, 8'h00, 0, 8'h00);
    chk("R10 restart done", strongUpEn, 8'h00);

    // pseudo-random traffic compared every clock
    lfsr = 8'hA5;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] | lfsr[3], lfsr ^ 8'h3C, lfsr[6] & lfsr[1],
           {lfsr[3:0], lfsr[7:4]});
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule